// File: doc/BRIEF.md
# SRAM LFSR Pattern Self-Test Engine

This block runs a built-in self-test on a small word-oriented embedded SRAM. When it is started it first writes zero to every location. It then makes a number of sweeps in which each location is read and, on the next cycle, rewritten with a fresh pseudo-random word. The word comes from a 4-bit linear feedback shift register, copied across the data width with a rotation that differs from slice to slice.

The first sweep only exercises the array. Its reads are not compressed. In every later sweep, each word read back is folded into a multiple-input signature register as wide as the data bus. There is no comparator for each word. After the last sweep the engine raises done and holds the signature steady. The surrounding logic can then shift it out and compare it with a golden value.

The array may have fewer words than its address space covers. Addresses past the last word are mirrored onto word 0 or word 1 by their LSB, and writes to them have no effect. By default the engine sweeps only the real words. A parameter makes it sweep the whole address space, including the mirrored part.

Top module: `sram_lfsr_bist`

## Requirements
- R1: `done_o` and `mem_en_o` are low after reset. A `start_i` pulse in idle or done state starts a run. `done_o` stays low for the whole run, rises in the cycle after the last write, and stays high until the next `start_i`.
- R2: The run begins with a clear sweep. There is one write per cycle, with `mem_wdata_o` all zero, at ascending addresses from 0.
- R3: After the clear sweep come `NUM_PASSES+1` pattern sweeps over ascending addresses. Each address gets a read cycle (`mem_en_o`=1, `mem_we_o`=0) followed at once by a write cycle to the same address. The memory returns read data on `mem_rdata_i` one cycle after the read.
- R4: The pattern state `s` is 4 bits wide. It is reset to 4'b0001 at start and steps as `s <= {s[2:0], s[3]^s[2]}` (x^4+x^3+1) after every pattern write. Bits [4k+3:4k] of `mem_wdata_o` hold `s` rotated left by k mod 4, and the top word is truncated to `DATA_W`.
- R5: `sig_o` is cleared to zero at start. It does not change during the clear sweep or during the first pattern sweep, so dummy reads are never compressed.
- R6: In each write cycle of a later sweep, `sig_o` becomes `{sig[W-2:0],0} ^ (sig[W-1] ? mask : 0) ^ rdata`. Here rdata is the word read in the previous cycle, and mask has bits 0, 1, 4 and 9 set.
- R7: With `SWEEP_ALIAS`=0, addresses run from 0 to `DEPTH-1`. With `SWEEP_ALIAS`=1 they run from 0 to 2^`ADDR_W`-1. Mirrored reads then feed the signature, and mirrored writes leave words 0 and 1 unchanged.
- R8: While `done_o` is high and `start_i` is low, `sig_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a test run |
| done_o | output | 1 | Run complete, signature valid |
| sig_o | output | DATA_W | Signature register |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, one cycle after a read |

## Verification
The bench aims at the sweep boundaries and the signature timing. If the engine compressed the dummy reads of the first sweep, `sig_o` would leave zero early. If it took read data a cycle late, or before the memory returns it, the signature would diverge on the first compacting word.

An engine that stepped the pattern generator on reads, or did not reseed it, would put out the wrong `mem_wdata_o` words. The mirrored sweep checks that writes past the real words do not corrupt words 0 and 1. It also checks that reads there feed the signature with mirrored data. A second default run after the first shows any state that survives from one run to the next.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_RD    = 3'd2,
    ST_WR    = 3'd3,
    ST_DONE  = 3'd4
  } bist_state_e;

  function automatic logic [3:0] rotl4(input logic [3:0] v, input int unsigned r);
    case (r % 4)
      1:       rotl4 = {v[2:0], v[3]};
      2:       rotl4 = {v[1:0], v[3:2]};
      3:       rotl4 = {v[0], v[3:1]};
      default: rotl4 = v;
    endcase
  endfunction
endpackage

// File: rtl/bist_seq.sv
module bist_seq
  import bist_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DEPTH       = 34,
  parameter int NUM_PASSES  = 13,
  parameter bit SWEEP_ALIAS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              en_o,
  output logic              we_o,
  output logic              clear_o,
  output logic              step_o,
  output logic              compact_o,
  output logic              init_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int PASS_TOT = NUM_PASSES + 1;
  localparam int PASS_W   = $clog2(PASS_TOT + 1);
  localparam int LAST_INT = SWEEP_ALIAS ? (1 << ADDR_W) - 1 : DEPTH - 1;
  localparam logic [ADDR_W-1:0] LAST = LAST_INT[ADDR_W-1:0];
  localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(PASS_TOT - 1);

  bist_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PASS_W-1:0] pass_q, pass_d;
  logic              at_last;

  assign at_last = (addr_q == LAST);
  assign init_o  = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    pass_d  = pass_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) begin
        state_d = ST_CLEAR;
        addr_d  = '0;
        pass_d  = '0;
      end
      ST_CLEAR: begin
        addr_d = at_last ? '0 : addr_q + 1'b1;
        if (at_last) state_d = ST_RD;
      end
      ST_RD: state_d = ST_WR;
      ST_WR: begin
        if (!at_last) begin
          addr_d  = addr_q + 1'b1;
          state_d = ST_RD;
        end else if (pass_q == PASS_LAST) begin
          state_d = ST_DONE;
        end else begin
          addr_d  = '0;
          pass_d  = pass_q + 1'b1;
          state_d = ST_RD;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pass_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      pass_q  <= pass_d;
    end
  end

  assign en_o      = (state_q == ST_CLEAR) || (state_q == ST_RD) || (state_q == ST_WR);
  assign we_o      = (state_q == ST_CLEAR) || (state_q == ST_WR);
  assign clear_o   = (state_q == ST_CLEAR);
  assign step_o    = (state_q == ST_WR);
  assign compact_o = (state_q == ST_WR) && (pass_q != '0);
  assign done_o    = (state_q == ST_DONE);
  assign addr_o    = addr_q;

  // R7: never address past the configured sweep end
  a_r7_addr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> (addr_o <= LAST));

  // R2: clear sweep advances one address per cycle
  a_r2_clear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_o && addr_o != LAST) |=> (clear_o && addr_o == $past(addr_o) + 1'b1));
endmodule

// File: rtl/bist_lfsr_gen.sv
module bist_lfsr_gen
  import bist_pkg::*;
#(
  parameter int DATA_W = 140
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              step_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int NSL = (DATA_W + 3) / 4;
  localparam logic [3:0] SEED = 4'b0001;

  logic [3:0]       s_q;
  logic [NSL*4-1:0] full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= SEED;
    else if (init_i) s_q <= SEED;
    else if (step_i) s_q <= {s_q[2:0], s_q[3] ^ s_q[2]};
  end

  for (genvar k = 0; k < NSL; k++) begin : g_slice
    assign full[4*k +: 4] = rotl4(s_q, k);
  end

  assign word_o = full[DATA_W-1:0];

  // R4: state never collapses to the all-zero lock-up value
  a_r4_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_q != 4'b0000);
endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int DATA_W = 140,
  parameter int TAP_A  = 1,
  parameter int TAP_B  = 4,
  parameter int TAP_C  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              compact_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] sig_o
);
  localparam logic [DATA_W-1:0] MASK = (DATA_W'(1)) | (DATA_W'(1) << TAP_A)
                                     | (DATA_W'(1) << TAP_B) | (DATA_W'(1) << TAP_C);
  logic [DATA_W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sig_q <= '0;
    else if (init_i)    sig_q <= '0;
    else if (compact_i) sig_q <= {sig_q[DATA_W-2:0], 1'b0}
                                 ^ ({DATA_W{sig_q[DATA_W-1]}} & MASK) ^ data_i;
  end

  assign sig_o = sig_q;

  // R5: signature moves only on a compaction or a restart
  a_r5_hold_unless_compact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!compact_i && !init_i) |=> $stable(sig_o));

  a_r5_cleared_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (sig_o == '0));
endmodule

// File: rtl/sram_lfsr_bist.sv
module sram_lfsr_bist #(
  parameter int DATA_W      = 140,
  parameter int ADDR_W      = 6,
  parameter int DEPTH       = 34,
  parameter int NUM_PASSES  = 13,
  parameter bit SWEEP_ALIAS = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              done_o,
  output logic [DATA_W-1:0] sig_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              clear, step, compact, init;
  logic [DATA_W-1:0] pat_word;

  bist_seq #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .NUM_PASSES(NUM_PASSES), .SWEEP_ALIAS(SWEEP_ALIAS)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .en_o(mem_en_o), .we_o(mem_we_o), .clear_o(clear), .step_o(step),
    .compact_o(compact), .init_o(init), .done_o(done_o), .addr_o(mem_addr_o)
  );

  bist_lfsr_gen #(.DATA_W(DATA_W)) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init), .step_i(step), .word_o(pat_word)
  );

  bist_misr #(.DATA_W(DATA_W)) u_misr (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(init), .compact_i(compact),
    .data_i(mem_rdata_i), .sig_o(sig_o)
  );

  assign mem_wdata_o = clear ? '0 : pat_word;

  // R3: a read is always followed by a write to the same address
  a_r3_read_then_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !mem_we_o) |=> (mem_en_o && mem_we_o && mem_addr_o == $past(mem_addr_o)));

  // R1: no memory traffic once done
  a_r1_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_en_o);

  // R8: signature frozen while done and not restarted
  a_r8_sig_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(sig_o));
endmodule

// File: tb/sram_lfsr_bist_tb.sv
module sram_lfsr_bist_tb;
  localparam int W  = 140;
  localparam int AW = 6;
  localparam int D  = 34;
  localparam int NP = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #5 clk = ~clk;

  logic          done_a, en_a, we_a, done_b, en_b, we_b;
  logic [W-1:0]  sig_a, wd_a, rd_a, sig_b, wd_b, rd_b;
  logic [AW-1:0] ad_a, ad_b;
  logic [W-1:0]  mem_a [D];
  logic [W-1:0]  mem_b [D];
  bit            sel = 1'b0;

  sram_lfsr_bist #(.DATA_W(W), .ADDR_W(AW), .DEPTH(D), .NUM_PASSES(NP), .SWEEP_ALIAS(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start && !sel), .done_o(done_a), .sig_o(sig_a),
    .mem_en_o(en_a), .mem_we_o(we_a), .mem_addr_o(ad_a), .mem_wdata_o(wd_a), .mem_rdata_i(rd_a));

  sram_lfsr_bist #(.DATA_W(W), .ADDR_W(AW), .DEPTH(D), .NUM_PASSES(NP), .SWEEP_ALIAS(1'b1)) u_dut_alias (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start && sel), .done_o(done_b), .sig_o(sig_b),
    .mem_en_o(en_b), .mem_we_o(we_b), .mem_addr_o(ad_b), .mem_wdata_o(wd_b), .mem_rdata_i(rd_b));

  function automatic int amap(input int a);
    return (a < D) ? a : (a % 2);
  endfunction

  // memory models: 1-cycle read, mirrored upper range, writes there dropped
  always @(posedge clk) begin
    if (en_a && !we_a) rd_a <= mem_a[amap(int'(ad_a))];
    if (en_a && we_a && int'(ad_a) < D) mem_a[ad_a] <= wd_a;
    if (en_b && !we_b) rd_b <= mem_b[amap(int'(ad_b))];
    if (en_b && we_b && int'(ad_b) < D) mem_b[ad_b] <= wd_b;
  end

  logic          s_done, s_en, s_we;
  logic [W-1:0]  s_sig, s_wd;
  logic [AW-1:0] s_ad;
  assign s_done = sel ? done_b : done_a;
  assign s_en   = sel ? en_b : en_a;
  assign s_we   = sel ? we_b : we_a;
  assign s_sig  = sel ? sig_b : sig_a;
  assign s_wd   = sel ? wd_b : wd_a;
  assign s_ad   = sel ? ad_b : ad_a;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] pat(input int s);
    logic [W-1:0] w;
    for (int b = 0; b < W; b++) begin
      int k = b / 4;
      int r = k % 4;
      int v = ((s << r) | (s >> (4 - r))) & 15;
      w[b] = v[b % 4];
    end
    return w;
  endfunction

  function automatic logic [W-1:0] misr_step(input logic [W-1:0] sg, input logic [W-1:0] d);
    logic [W-1:0] m = '0;
    logic [W-1:0] n;
    m[0] = 1'b1; m[1] = 1'b1; m[4] = 1'b1; m[9] = 1'b1;
    n = sg << 1;
    if (sg[W-1]) n = n ^ m;
    return n ^ d;
  endfunction

  task automatic run(input bit al);
    int last = al ? (1 << AW) - 1 : D - 1;
    int s = 1;
    logic [W-1:0] em [D];
    logic [W-1:0] esig = '0;
    logic [W-1:0] rdv;
    logic [W-1:0] held;
    @(negedge clk); sel = al; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(s_done == 1'b0, "R1 done low while running", W'(s_done), '0);
    for (int a = 0; a <= last; a++) begin
      chk(s_en && s_we && int'(s_ad) == a, "R2 clear write addr", W'({s_en, s_we, s_ad}), W'({2'b11, AW'(a)}));
      chk(s_wd == '0, "R2 clear data zero", s_wd, '0);
      chk(s_sig == '0, "R5 sig zero in clear", s_sig, '0);
      if (a < D) em[a] = '0;
      @(negedge clk);
    end
    for (int p = 0; p <= NP; p++) begin
      for (int a = 0; a <= last; a++) begin
        chk(s_en && !s_we && int'(s_ad) == a, (a >= D) ? "R7 aliased read addr" : "R3 read addr",
            W'({s_en, s_we, s_ad}), W'({2'b10, AW'(a)}));
        chk(s_sig == esig, (p == 0) ? "R5 no dummy compaction" : "R6 signature", s_sig, esig);
        rdv = em[amap(a)];
        @(negedge clk);
        chk(s_en && s_we && int'(s_ad) == a, "R3 write follows read", W'({s_en, s_we, s_ad}), W'({2'b11, AW'(a)}));
        chk(s_wd == pat(s), "R4 pattern word", s_wd, pat(s));
        chk(!s_done, "R1 done low while running", W'(s_done), '0);
        if (p > 0) esig = misr_step(esig, rdv);
        if (a < D) em[a] = pat(s);
        s = ((s << 1) & 15) | (((s >> 3) ^ (s >> 2)) & 1);
        @(negedge clk);
      end
    end
    chk(s_done == 1'b1, "R1 done after last write", W'(s_done), W'(1));
    chk(s_sig == esig, al ? "R7 aliased final signature" : "R6 final signature", s_sig, esig);
    chk(!s_en, "R1 no access when done", W'(s_en), '0);
    held = s_sig;
    repeat (5) @(negedge clk);
    chk(s_sig == held && s_done, "R8 signature held", s_sig, held);
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done_a && !en_a && sig_a == '0, "R1 reset state", sig_a, '0);
    chk(!done_b && !en_b, "R1 reset state alias", W'({done_b, en_b}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    run(1'b0);
    run(1'b1);
    run(1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule